// File: doc/BRIEF.md
# Two-Wire Command Word Receiver

This block is a target on a two-wire serial bus (I2C). It feeds a command decoder that governs a one-time-programmable settings store. Both bus lines come in unsynchronised. Each line passes through a two-flop synchronizer and then a stable-count filter, and only after that is it examined for START, repeated START and STOP conditions and for clock edges. The 7-bit target address is the fixed prefix 0b01011 followed by two low bits. Those two bits are decoded from a strap input with three levels.

A write transaction carries whole 16-bit command words. Each word is two data bytes sent high byte first. Any number of words may follow a single address byte. Each completed byte pair is handed to the decoder as one word, marked by a one-cycle valid strobe. A read transaction returns a 16-bit response supplied by the decoder, sent as two bytes MSB first. The response is captured when the address is acknowledged. The open-drain SDA pad is modelled as an active-high pull-down enable. The block does not stretch the clock.

Top module: `i2c_cmd_framer`

## Requirements
- R1: After reset, `sdaOe` is 0 and `cmdValid` is 0.
- R2: The target address is {0b01011, A1, A0}. `strapLevel` 2'b00 (pin tied low) gives A1A0 = 11, 2'b01 (tied high) gives 00, and 2'b10 or 2'b11 (floating) gives 10. Any other address byte receives no ACK.
- R3: The target pulls SDA low during the ninth clock of a matching address byte and of every write data byte. `cmdValid` is only ever high while that ACK is being driven.
- R4: In a write transaction, each pair of data bytes produces `cmdWord` = {first byte, second byte} together with a `cmdValid` pulse one cycle wide. Several words may share one transaction. `cmdWord` holds its value until the next word.
- R5: If a STOP or repeated START arrives after an odd number of data bytes, the partial byte is discarded without a strobe. The next byte starts a new word.
- R6: After an address mismatch, the target neither acknowledges nor produces words until the next START or STOP.
- R7: On a read, the target sends 16 bits MSB first. Bits 15:14 are always 0, and bits 13:0 are `rspWord` as sampled when the address ACK begins. Later changes to `rspWord` have no effect on that transaction.
- R8: If the controller ACKs the first read byte, the second byte follows. After the second byte, or after a NACK on the first, the target leaves SDA released until the next START.
- R9: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks is not seen as an edge, START or STOP.
- R10: A repeated START begins a new address phase, which may switch the transfer direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| strapLevel | input | 2 | Decoded three-level address strap (00 low, 01 high, 1x floating) |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| sdaOe | output | 1 | 1 pulls SDA low |
| rspWord | input | 16 | Response word from the decoder |
| cmdValid | output | 1 | One-cycle strobe, new command word |
| cmdWord | output | 16 | Last assembled command word |

## Verification
The bench builds the block with `FILT_LEN` = 4 and a bus quarter period of ten system clocks. With this setting, a two-cycle spike injected on SCL while it is low, or on SDA while SCL is high, lies below the filter threshold. An unfiltered spike would add a clock bit or create a false START, so either failure shows up as a wrong word or a missing word. Because the quarter period is short, the filter and synchronizer latency of roughly seven cycles becomes a real constraint on when the ACK and read data must settle. Every strap level, odd-byte aborts, repeated START turnarounds and both read endings are run against a queue of expected words.

// File: rtl/i2c_framer_pkg.sv
package i2c_framer_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } fsmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // sample SDA, count a bit
    logic clrBits;   // restart bit count
    logic loadRsp;   // latch response word
    logic shiftTx;   // advance read shifter
    logic takeHigh;  // park first byte of a word
    logic emitWord;  // publish assembled word
  } dpStrobe_t;

  function automatic logic [1:0] strapToLow(input logic [1:0] strap);
    case (strap)
      2'b00:   return 2'b11;
      2'b01:   return 2'b00;
      default: return 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          meta;
  logic          syncQ;
  logic          outQ;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta  <= 1'b1;
      syncQ <= 1'b1;
      outQ  <= 1'b1;
      cnt   <= '0;
    end else begin
      meta  <= rawIn;
      syncQ <= meta;
      if (syncQ == outQ) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        outQ <= syncQ;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign cleanOut = outQ;

  AST_FILTER_SETTLED: assert property (@(posedge clk) disable iff (!rstN)
    (outQ != $past(outQ)) |-> ($past(syncQ) == outQ)); // R9

endmodule

// File: rtl/i2c_frame_dp.sv
module i2c_frame_dp
  import i2c_framer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         ctl,
  input  logic              sdaF,
  input  logic [WORD_W-1:0] rspWord,
  output logic [BYTE_W-1:0] rxByte,
  output logic              bitsFull,
  output logic              txBit,
  output logic              cmdValid,
  output logic [WORD_W-1:0] cmdWord
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] hiByte;
  logic [WORD_W-1:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      hiByte   <= '0;
      txShift  <= '0;
      cmdValid <= 1'b0;
      cmdWord  <= '0;
    end else begin
      cmdValid <= ctl.emitWord;
      if (ctl.clrBits) begin
        bitCnt <= '0;
      end else if (ctl.capture) begin
        bitCnt  <= bitCnt + 1'b1;
        rxShift <= {rxShift[BYTE_W-2:0], sdaF};
      end
      if (ctl.takeHigh) hiByte <= rxShift;
      if (ctl.emitWord) cmdWord <= {hiByte, rxShift};
      if (ctl.loadRsp) begin
        txShift <= {2'b00, rspWord[WORD_W-3:0]};
      end else if (ctl.shiftTx) begin
        txShift <= {txShift[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign rxByte   = rxShift;
  assign bitsFull = (bitCnt == CNT_W'(BYTE_W));
  assign txBit    = txShift[WORD_W-1];

  AST_VALID_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid); // R4
  AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadRsp && !ctl.shiftTx) |=> $stable(txShift)); // R7

endmodule

// File: rtl/i2c_frame_ctrl.sv
module i2c_frame_ctrl
  import i2c_framer_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b01011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic [1:0]        strapLevel,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              bitsFull,
  input  logic              txBit,
  output dpStrobe_t         ctl,
  output logic              sdaOe
);
  fsmState_t state, stateN;
  logic sclQ, sdaQ;
  logic rnw, rnwN;
  logic byteOdd, oddN;
  logic rdSecond, secN;
  logic mAck, ackN;

  logic sclRise, sclFall, startDet, stopDet;
  logic [6:0] ownAddr;

  assign sclRise  = sclF & ~sclQ;
  assign sclFall  = ~sclF & sclQ;
  assign startDet = sclF & sclQ & sdaQ & ~sdaF;
  assign stopDet  = sclF & sclQ & ~sdaQ & sdaF;
  assign ownAddr  = {ADDR_HI, strapToLow(strapLevel)};

  always_comb begin
    ctl    = '0;
    stateN = state;
    rnwN   = rnw;
    oddN   = byteOdd;
    secN   = rdSecond;
    ackN   = mAck;
    if (startDet) begin
      stateN      = ST_ADDR;
      ctl.clrBits = 1'b1;
      oddN        = 1'b0;
    end else if (stopDet) begin
      stateN = ST_IDLE;
      oddN   = 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise) begin
            ctl.capture = 1'b1;
          end else if (sclFall && bitsFull) begin
            if (rxByte[7:1] == ownAddr) begin
              stateN      = ST_ADDR_ACK;
              rnwN        = rxByte[0];
              ctl.loadRsp = rxByte[0];
            end else begin
              stateN = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ctl.clrBits = 1'b1;
            secN        = 1'b0;
            stateN      = rnw ? ST_RD_BYTE : ST_WR_BYTE;
          end
        end
        ST_WR_BYTE: begin
          if (sclRise) begin
            ctl.capture = 1'b1;
          end else if (sclFall && bitsFull) begin
            stateN = ST_WR_ACK;
            if (byteOdd) begin
              ctl.emitWord = 1'b1;
              oddN         = 1'b0;
            end else begin
              ctl.takeHigh = 1'b1;
              oddN         = 1'b1;
            end
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            ctl.clrBits = 1'b1;
            stateN      = ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (sclRise) begin
            ctl.capture = 1'b1;
          end else if (sclFall) begin
            ctl.shiftTx = 1'b1;
            if (bitsFull) stateN = ST_RD_ACK;
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            ackN = ~sdaF;
          end else if (sclFall) begin
            if (mAck && !rdSecond) begin
              stateN      = ST_RD_BYTE;
              ctl.clrBits = 1'b1;
              secN        = 1'b1;
            end else begin
              stateN = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sclQ     <= 1'b1;
      sdaQ     <= 1'b1;
      rnw      <= 1'b0;
      byteOdd  <= 1'b0;
      rdSecond <= 1'b0;
      mAck     <= 1'b0;
    end else begin
      state    <= stateN;
      sclQ     <= sclF;
      sdaQ     <= sdaF;
      rnw      <= rnwN;
      byteOdd  <= oddN;
      rdSecond <= secN;
      mAck     <= ackN;
    end
  end

  assign sdaOe = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                 ((state == ST_RD_BYTE) && !txBit);

  AST_RELEASE_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe); // R6

endmodule

// File: rtl/i2c_cmd_framer.sv
module i2c_cmd_framer
  import i2c_framer_pkg::*;
#(
  parameter int         FILT_LEN = 5,
  parameter logic [4:0] ADDR_HI  = 5'b01011
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  strapLevel,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaOe,
  input  logic [15:0] rspWord,
  output logic        cmdValid,
  output logic [15:0] cmdWord
);
  logic [1:0]        rawLines;
  logic [1:0]        cleanLines;
  dpStrobe_t         ctl;
  logic [BYTE_W-1:0] rxByte;
  logic              bitsFull;
  logic              txBit;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : gLine
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) uFilt (
      .clk      (clk),
      .rstN     (rstN),
      .rawIn    (rawLines[g]),
      .cleanOut (cleanLines[g])
    );
  end

  i2c_frame_ctrl #(.ADDR_HI(ADDR_HI)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclF       (cleanLines[0]),
    .sdaF       (cleanLines[1]),
    .strapLevel (strapLevel),
    .rxByte     (rxByte),
    .bitsFull   (bitsFull),
    .txBit      (txBit),
    .ctl        (ctl),
    .sdaOe      (sdaOe)
  );

  i2c_frame_dp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .sdaF     (cleanLines[1]),
    .rspWord  (rspWord),
    .rxByte   (rxByte),
    .bitsFull (bitsFull),
    .txBit    (txBit),
    .cmdValid (cmdValid),
    .cmdWord  (cmdWord)
  );

  AST_ACK_WITH_WORD: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> sdaOe); // R3

endmodule

// File: tb/tb_i2c_cmd_framer.sv
module tb_i2c_cmd_framer;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int FILT       = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  strap = 2'b00;
  logic        sclDrv = 1'b1;
  logic        sdaDrv = 1'b1;
  logic [15:0] rsp = 16'h0000;
  logic        sdaOe;
  logic        cmdValid;
  logic [15:0] cmdWord;
  logic        sdaLine;

  assign sdaLine = sdaDrv & ~sdaOe;

  i2c_cmd_framer #(.FILT_LEN(FILT)) dut (
    .clk(clk), .rstN(rstN), .strapLevel(strap), .sclIn(sclDrv), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .rspWord(rsp), .cmdValid(cmdValid), .cmdWord(cmdWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [15:0] w; string req; } expItem_t;
  expItem_t expQ[$];
  int    nChecks = 0;
  int    nFail = 0;
  string curReq = "R1";

  task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare each strobe against the queue
  always @(negedge clk) begin
    if (rstN && cmdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, curReq, cmdWord, 16'h0000);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(cmdWord == it.w, it.req, cmdWord, it.w);
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitCyc(Q);
    sclDrv = 1'b1; waitCyc(Q);
    sdaDrv = 1'b0; waitCyc(Q);
    sclDrv = 1'b0; waitCyc(Q);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitCyc(Q);
    sclDrv = 1'b1; waitCyc(Q);
    sdaDrv = 1'b1; waitCyc(2*Q);
  endtask

  // glitch 1: SCL spike while low, glitch 2: SDA spike while SCL high
  task automatic bitCycle(input logic b, input int glitch, output logic r);
    sdaDrv = b;
    waitCyc(4);
    if (glitch == 1) begin sclDrv = 1'b1; waitCyc(2); sclDrv = 1'b0; end
    else waitCyc(2);
    waitCyc(4);
    sclDrv = 1'b1;
    waitCyc(4);
    r = sdaLine;
    if (glitch == 2) begin sdaDrv = ~b; waitCyc(2); sdaDrv = b; end
    else waitCyc(2);
    waitCyc(4);
    sclDrv = 1'b0;
    waitCyc(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, input int glitch, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) bitCycle(v[i], (i == 3) ? glitch : 0, r);
    bitCycle(1'b1, 0, r);
    acked = !r;
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, 0, r);
      v[i] = r;
    end
    bitCycle(!mAck, 0, r);
  endtask

  task automatic writeWord(input logic [15:0] w, input string req, input int glitch);
    logic a;
    expItem_t it;
    it.w = w; it.req = req;
    expQ.push_back(it);
    sendByte(w[15:8], 0, a);
    check(a, "R3", {15'd0, a}, 16'd1);
    sendByte(w[7:0], glitch, a);
    check(a, "R3", {15'd0, a}, 16'd1);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL %s watchdog expired actual=running expected=done", curReq);
    summary();
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b1, b2, b3;
    waitCyc(5);
    check(sdaOe == 1'b0, "R1", {15'd0, sdaOe}, 16'd0);
    check(cmdValid == 1'b0, "R1", {15'd0, cmdValid}, 16'd0);
    rstN = 1'b1;
    waitCyc(20);

    // strap low: address 0x2F, two words in one transaction
    curReq = "R4";
    strap = 2'b00;
    busStart();
    sendByte({7'h2F, 1'b0}, 0, a);
    check(a, "R2", {15'd0, a}, 16'd1);
    writeWord(16'h0503, "R4", 0);
    writeWord(16'h1C03, "R4", 0);
    busStop();
    check(expQ.size() == 0, "R4", 16'(expQ.size()), 16'd0);
    check(cmdWord == 16'h1C03, "R4", cmdWord, 16'h1C03);

    // strap high: address 0x2C; foreign address ignored
    curReq = "R6";
    strap = 2'b01;
    busStart();
    sendByte({7'h2F, 1'b0}, 0, a);
    check(!a, "R2", {15'd0, a}, 16'd0);
    sendByte(8'h11, 0, a);
    check(!a, "R6", {15'd0, a}, 16'd0);
    sendByte(8'h22, 0, a);
    check(!a, "R6", {15'd0, a}, 16'd0);
    busStop();
    busStart();
    sendByte({7'h2C, 1'b0}, 0, a);
    check(a, "R2", {15'd0, a}, 16'd1);
    writeWord(16'h0123, "R2", 0);
    busStop();

    // floating strap: address 0x2E; odd-byte aborts
    curReq = "R5";
    strap = 2'b10;
    busStart();
    sendByte({7'h2E, 1'b0}, 0, a);
    check(a, "R2", {15'd0, a}, 16'd1);
    sendByte(8'h05, 0, a);
    busStop();
    strap = 2'b11;
    busStart();
    sendByte({7'h2E, 1'b0}, 0, a);
    check(a, "R2", {15'd0, a}, 16'd1);
    sendByte(8'h07, 0, a);
    busStart();
    sendByte({7'h2E, 1'b0}, 0, a);
    check(a, "R10", {15'd0, a}, 16'd1);
    writeWord(16'h0800, "R5", 0);
    busStop();
    check(expQ.size() == 0, "R5", 16'(expQ.size()), 16'd0);

    // write then turnaround to read; response latched at address ACK
    curReq = "R7";
    strap = 2'b00;
    rsp = 16'hFFFF;
    busStart();
    sendByte({7'h2F, 1'b0}, 0, a);
    writeWord(16'h0800, "R4", 0);
    busStart();
    sendByte({7'h2F, 1'b1}, 0, a);
    check(a, "R10", {15'd0, a}, 16'd1);
    rsp = 16'h0000;
    readByte(1'b1, b1);
    readByte(1'b0, b2);
    check({b1, b2} == 16'h3FFF, "R7", {b1, b2}, 16'h3FFF);
    busStop();
    check(sdaOe == 1'b0, "R8", {15'd0, sdaOe}, 16'd0);

    // second read: top bits forced low, bus released afterwards
    rsp = 16'hC2A5;
    busStart();
    sendByte({7'h2F, 1'b1}, 0, a);
    readByte(1'b1, b1);
    readByte(1'b0, b2);
    check({b1, b2} == 16'h02A5, "R7", {b1, b2}, 16'h02A5);
    readByte(1'b0, b3);
    check(b3 == 8'hFF, "R8", {8'h00, b3}, 16'h00FF);
    busStop();

    // NACK on first byte ends the read
    curReq = "R8";
    rsp = 16'h0000;
    busStart();
    sendByte({7'h2F, 1'b1}, 0, a);
    readByte(1'b0, b1);
    check(b1 == 8'h00, "R7", {8'h00, b1}, 16'h0000);
    readByte(1'b0, b2);
    check(b2 == 8'hFF, "R8", {8'h00, b2}, 16'h00FF);
    busStop();

    // short spikes on both lines
    curReq = "R9";
    busStart();
    sendByte({7'h2F, 1'b0}, 0, a);
    writeWord(16'h1234, "R9", 1);
    writeWord(16'h0A5A, "R9", 2);
    busStop();
    check(expQ.size() == 0, "R9", 16'(expQ.size()), 16'd0);
    check(cmdWord == 16'h0A5A, "R4", cmdWord, 16'h0A5A);

    summary();
    $finish;
  end
endmodule